// File: doc/BRIEF.md
# Reference Clock Loss Detector

This block watches a reference clock from a separate, free-running sampling clock. The two clocks are unrelated. The reference is brought into the sampling domain through a chain of synchronizer flops, and any change of its level counts as activity. A counter measures how many sampling cycles have passed since the last activity. When the counter reaches a parameterised limit, the loss flag is set. The first returning reference transition clears the flag at once, and the counter starts again from zero.

While the flag is set, the block drives disable controls to the clock recovery function and to the jitter attenuator. It also raises two alarms, each gated by a configuration input:

- **Receive-invalid marker:** set only when clock recovery is in use.
- **Transmit clock loss alarm:** set only when the transmit-path jitter attenuator is enabled.

With the default limit and a 50 MHz sampling clock, the flag rises within 16 µs of the reference stopping. The reference must toggle more slowly than half the sampling rate.

Top module: `refclk_loss_detect`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, the loss flag and all four downstream outputs are 0 after that edge. After reset is released with the reference idle, the flag rises exactly `LOSS_CYCLES` sampling cycles after the last reset edge, because the counter restarts from zero.
- R2: After the last level change of `ref_clk`, `loss_o` rises exactly `LOSS_CYCLES + SYNC_STAGES + 1` sampling clock edges later. With the defaults (796, 2) this is 799 cycles, or 15.98 µs at 50 MHz.
- R3: When `ref_clk` changes level while `loss_o` is 1, `loss_o` is still 1 after `SYNC_STAGES` edges. It is 0 after edge `SYNC_STAGES + 1`.
- R4: If consecutive `ref_clk` level changes are at most `LOSS_CYCLES` sampling cycles apart, `loss_o` stays 0. If they are exactly `LOSS_CYCLES + 1` cycles apart, `loss_o` is high for exactly one sampled cycle per gap.
- R5: `cdr_off_o` and `ja_off_o` are both equal to `loss_o` at all times.
- R6: `rx_invalid_o` is 1 exactly when `loss_o` is 1 and `cdr_en` is 1.
- R7: With `cdr_en` at 0, `rx_invalid_o` stays 0 even while `loss_o` is 1, whatever the value of `tx_ja_en`.
- R8: `tx_clk_loss_o` is 1 exactly when `loss_o` is 1 and `tx_ja_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk | input | 1 | Monitored reference clock, asynchronous to `clk` |
| cdr_en | input | 1 | Clock recovery is in use on the receive side |
| tx_ja_en | input | 1 | Jitter attenuator is placed in the transmit path |
| loss_o | output | 1 | Loss-of-reference flag |
| cdr_off_o | output | 1 | Disable request to clock recovery |
| ja_off_o | output | 1 | Disable request to the jitter attenuator |
| rx_invalid_o | output | 1 | Receive clock, data rails and signal-loss outputs are not valid |
| tx_clk_loss_o | output | 1 | Transmit clock loss alarm |

## Verification
The hardest case to reach is the exact boundary of the timeout. A reference gap of `LOSS_CYCLES` cycles must leave the flag low. A gap one cycle longer must produce a single-cycle pulse that the very next transition clears.

The bench reaches this case by moving `ref_clk` only on falling edges of `clk`, so every gap is an exact number of sampling cycles. It then runs a train of transitions at each spacing and counts the high samples in every gap. The reset-restart and release latencies are reached the same way, by counting edges from a known transition.

// File: rtl/refclk_loss_pkg.sv
// Package: shared types for the reference clock loss detector.
// Assumes: single-bit controls and alarms, all in the sampling domain.
package refclk_loss_pkg;

    // Configuration of the downstream functions that the flag acts upon.
    typedef struct packed {
        logic cdr_en;     // clock recovery in use
        logic tx_ja_en;   // jitter attenuator in the transmit path
    } lossdet_cfg_t;

    // Controls and alarms derived from the loss flag.
    typedef struct packed {
        logic cdr_off;
        logic ja_off;
        logic rx_invalid;
        logic tx_clk_loss;
    } lossdet_act_t;

endpackage

// File: rtl/refclk_sampler.sv
// Module: refclk_sampler
// Brings the asynchronous reference level into the sampling domain through
// STAGES flops, then flags every level change with a one-cycle pulse.
// Assumes: the reference toggles more slowly than half the sampling rate,
// and the reset value of every stage is 0.
module refclk_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    output logic activity_o
);
    logic [STAGES-1:0] stage_q;
    logic              last_q;

    // First flop: capture the raw asynchronous level.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= 1'b0;
        else        stage_q[0] <= ref_in;
    end

    // Remaining flops: one per further stage of settling.
    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= 1'b0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    endgenerate

    // Hold the previous settled level for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= stage_q[STAGES-1];
    end

    // Any difference between the settled level and the held level is activity.
    assign activity_o = stage_q[STAGES-1] ^ last_q;

    // A pulse never lasts two cycles, because the held level catches up.
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        activity_o |=> (last_q == $past(stage_q[STAGES-1]))); // R3

endmodule

// File: rtl/refclk_timeout.sv
// Module: refclk_timeout
// Counts sampling cycles since the last activity pulse and sets the loss
// flag when the count reaches LIMIT. An activity pulse clears both counter
// and flag on the next edge. The counter saturates at LIMIT.
// Assumes: LIMIT >= 2.
module refclk_timeout #(
    parameter int LIMIT = 796
) (
    input  logic clk,
    input  logic rst_n,
    input  logic activity_i,
    output logic loss_o
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;

    // Idle-time counter: restart on activity, otherwise count up to LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (activity_i)      cnt_q <= '0;
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    // Loss flag: cleared by activity, set when the counter reaches LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n)                 flag_q <= 1'b0;
        else if (activity_i)        flag_q <= 1'b0;
        else if (cnt_q == CNT_LAST) flag_q <= 1'b1;
    end

    assign loss_o = flag_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX); // R2
    AST_RISE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> ($past(cnt_q) == CNT_LAST)); // R2
    AST_CLEAR_ON_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
        activity_i |=> !flag_q); // R3
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> !flag_q); // R1

endmodule

// File: rtl/refclk_loss_actions.sv
// Module: refclk_loss_actions
// Turns the loss flag into disable controls and gated alarms.
// Assumes: the flag is a registered signal in the sampling domain, so these
// outputs change only after clock edges or configuration changes.
module refclk_loss_actions
    import refclk_loss_pkg::*;
(
    input  logic         loss_i,
    input  lossdet_cfg_t cfg_i,
    output lossdet_act_t act_o
);
    // Disables follow the flag; each alarm is gated by its own enable.
    always_comb begin
        act_o.cdr_off     = loss_i;
        act_o.ja_off      = loss_i;
        act_o.rx_invalid  = loss_i & cfg_i.cdr_en;
        act_o.tx_clk_loss = loss_i & cfg_i.tx_ja_en;
    end

    always_comb begin
        AST_RX_NEEDS_CDR: assert (!act_o.rx_invalid || cfg_i.cdr_en); // R7
    end

endmodule

// File: rtl/refclk_loss_detect.sv
// Module: refclk_loss_detect (top)
// Monitors ref_clk from the free-running clk. Raises loss_o after
// LOSS_CYCLES idle sampling cycles and clears it on the first returning
// transition. It also drives the downstream disables and alarms.
// Assumes: ref_clk is slower than clk/2. Reset is synchronous, active low.
module refclk_loss_detect
    import refclk_loss_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LOSS_CYCLES = 796
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_clk,
    input  logic cdr_en,
    input  logic tx_ja_en,
    output logic loss_o,
    output logic cdr_off_o,
    output logic ja_off_o,
    output logic rx_invalid_o,
    output logic tx_clk_loss_o
);
    logic         activity;
    logic         loss;
    lossdet_cfg_t cfg;
    lossdet_act_t act;

    refclk_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_in     (ref_clk),
        .activity_o (activity)
    );

    refclk_timeout #(.LIMIT(LOSS_CYCLES)) u_timeout (
        .clk        (clk),
        .rst_n      (rst_n),
        .activity_i (activity),
        .loss_o     (loss)
    );

    // Gather the configuration inputs into one struct.
    always_comb begin
        cfg.cdr_en   = cdr_en;
        cfg.tx_ja_en = tx_ja_en;
    end

    refclk_loss_actions u_actions (
        .loss_i (loss),
        .cfg_i  (cfg),
        .act_o  (act)
    );

    assign loss_o        = loss;
    assign cdr_off_o     = act.cdr_off;
    assign ja_off_o      = act.ja_off;
    assign rx_invalid_o  = act.rx_invalid;
    assign tx_clk_loss_o = act.tx_clk_loss;

    AST_DISABLES_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cdr_off_o == loss_o) && (ja_off_o == loss_o)); // R5
    AST_RX_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_invalid_o |-> (loss_o && cdr_en)); // R6
    AST_TX_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clk_loss_o |-> (loss_o && tx_ja_en)); // R8

endmodule

// File: tb/tb_refclk_loss_detect.sv
module tb_refclk_loss_detect;
    localparam int N     = 2;
    localparam int LIMIT = 796;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_clk = 1'b0;
    logic cdr_en = 1'b0;
    logic tx_ja_en = 1'b0;
    logic loss_o, cdr_off_o, ja_off_o, rx_invalid_o, tx_clk_loss_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    refclk_loss_detect #(.SYNC_STAGES(N), .LOSS_CYCLES(LIMIT)) dut (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk),
        .cdr_en(cdr_en), .tx_ja_en(tx_ja_en),
        .loss_o(loss_o), .cdr_off_o(cdr_off_o), .ja_off_o(ja_off_o),
        .rx_invalid_o(rx_invalid_o), .tx_clk_loss_o(tx_clk_loss_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Advance n rising edges, then sample shortly after the last one.
    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // Change the reference level on a falling edge.
    task automatic flip_ref();
        @(negedge clk);
        ref_clk = ~ref_clk;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ref_clk = 1'b0;
        cdr_en = 1'b1;
        tx_ja_en = 1'b1;
        edges(4);
        chk("R1 loss in reset", loss_o, 0);
        chk("R1 outputs in reset",
            cdr_off_o | ja_off_o | rx_invalid_o | tx_clk_loss_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        edges(LIMIT - 1);
        chk("R1 restart before limit", loss_o, 0);
        edges(1);
        chk("R1 restart at limit", loss_o, 1);
    endtask

    task automatic t_clear();
        flip_ref();
        edges(N);
        chk("R3 still set", loss_o, 1);
        edges(1);
        chk("R3 cleared", loss_o, 0);
    endtask

    // Call right after t_clear: N+1 edges since the transition have passed.
    task automatic t_timeout();
        edges(LIMIT - 1);
        chk("R2 before timeout", loss_o, 0);
        edges(1);
        chk("R2 at timeout", loss_o, 1);
    endtask

    // Runs with loss_o = 1 and checks every configuration combination.
    task automatic t_policy();
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            cdr_en = k[0];
            tx_ja_en = k[1];
            edges(1);
            chk("R5 cdr_off", cdr_off_o, 1);
            chk("R5 ja_off", ja_off_o, 1);
            if (k[0] == 1'b0)
                chk("R7 rx_invalid with cdr off", rx_invalid_o, 0);
            else
                chk("R6 rx_invalid", rx_invalid_o, 1);
            chk("R8 tx_clk_loss", tx_clk_loss_o, k[1]);
        end
        @(negedge clk);
        cdr_en = 1'b1;
        tx_ja_en = 1'b1;
    endtask

    // Runs with loss_o = 0 and all enables set.
    task automatic t_policy_idle();
        edges(1);
        chk("R5 disables idle", cdr_off_o | ja_off_o, 0);
        chk("R6 rx_invalid idle", rx_invalid_o, 0);
        chk("R8 tx_clk_loss idle", tx_clk_loss_o, 0);
    endtask

    // Each gap is h cycles long; returns the high-sample count of the last gap.
    task automatic t_train(input int h, input int gaps, output int highs_last,
                           output int highs_all);
        highs_all = 0;
        highs_last = 0;
        for (int g = 0; g < gaps; g++) begin
            int cnt = 0;
            @(negedge clk);
            ref_clk = ~ref_clk;
            for (int c = 0; c < h; c++) begin
                @(posedge clk);
                #2;
                if (loss_o) cnt++;
            end
            highs_all += cnt;
            highs_last = cnt;
        end
    endtask

    task automatic t_toggle();
        int last, all;
        t_train(3, 300, last, all);
        chk("R4 fast reference", all, 0);
        t_train(LIMIT, 4, last, all);
        chk("R4 gap equal to limit", all, 0);
        t_train(LIMIT + 1, 3, last, all);
        chk("R4 gap one past limit", last, 1);
    endtask

    initial begin
        t_reset();
        t_clear();
        t_timeout();
        t_policy();
        t_clear();
        t_policy_idle();
        t_toggle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule